// File: doc/BRIEF.md
# Four-Lane Block Transpose Loader

This block sits in front of a four-way parallel hash datapath. Each of the four lanes owns its own 64-byte message block. The loader takes those blocks in as 128-bit rows, one row per lane per beat. Each row holds four consecutive 32-bit words of that lane. The loader swaps rows and columns, so that each stored vector carries the same word index from every lane. It also reverses the byte order inside every 32-bit word. Four accepted beats fill a 16-entry store of schedule words, which the hash core then reads by index.

The loader keeps one read pointer per lane. A memory fetcher outside the block uses these pointers as the byte address of the next row. Each pointer moves forward by one row width per accepted beat, so it moves by one block length per completed block. Rows arrive over a valid/ready handshake. When the sixteenth word is written, the loader raises a one-cycle done pulse and refuses further rows until the consumer releases the store.

Top module: `lane_block_loader`

## Requirements
- R1: Stored vector k carries word k of lanes 0 to 3. Lane l occupies bits [32l+31:32l] of the vector, so lane 0 is the least significant slot. In the input row of lane l (bits [128l+127:128l] of `row_data`), word k sits at bits [32k+31:32k].
- R2: Every 32-bit word is stored byte-reversed. An input word with bytes b3 b2 b1 b0 (b0 least significant) is stored as b0 b1 b2 b3. For example, 0x0205A53C becomes 0x3CA50502.
- R3: The g-th accepted beat of a block (g = 0..3) writes store entries 4g, 4g+1, 4g+2 and 4g+3, in that order of word index. Reading entry e through `rd_idx` returns it on `rd_word` in the same cycle.
- R4: Each accepted beat advances every lane pointer on `lane_addr` by 16 bytes, modulo 2^32. A full block therefore advances each pointer by 64.
- R5: When `ptr_load` is high, `row_ready` is low in that cycle. After the next edge, `lane_addr` equals `ptr_init`. The beat count within the current block is kept.
- R6: After the edge that accepts the fourth beat of a block, `done` is high for exactly one cycle and `buf_full` is high.
- R7: While `buf_full` is high, `row_ready` is low. Offered rows change neither the store nor the pointers.
- R8: A cycle with `consume` high while the store is full clears `buf_full` at the next edge, and rows are accepted again. `consume` while the store is empty has no effect.
- R9: A synchronous reset returns the beat count to 0 and clears `buf_full`, `done` and all lane pointers. `row_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_load | input | 1 | Load all lane pointers from `ptr_init` |
| ptr_init | input | 128 | New pointer values, lane l at bits [32l+31:32l] |
| lane_addr | output | 128 | Current lane byte pointers, lane l at bits [32l+31:32l] |
| row_valid | input | 1 | A row per lane is offered on `row_data` |
| row_ready | output | 1 | The loader accepts the offered rows this cycle |
| row_data | input | 512 | Four 128-bit rows, lane l at bits [128l+127:128l] |
| done | output | 1 | One-cycle pulse after the block's last beat is stored |
| buf_full | output | 1 | The store holds a complete block not yet released |
| consume | input | 1 | Releases a full store |
| rd_idx | input | 4 | Store entry to read |
| rd_word | output | 128 | Lane-interleaved vector at entry `rd_idx` |

## Verification
The bench builds the loader with its default parameters: four lanes, 32-bit words, four words per row and a 16-word block. These keep the exact 4x4 slot mapping and the 16-byte pointer step in view. Lane pointers are loaded close to 2^32, so address wrap-around occurs within the first blocks. The pointer reload and the reset are both placed in the middle of a block, so that a kept beat count and a cleared beat count each show up in the position of the done pulse.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
    localparam int BYTE_W        = 8;
    localparam int DEF_LANES     = 4;
    localparam int DEF_WORD_W    = 32;
    localparam int DEF_ROW_WORDS = 4;
    localparam int DEF_BLK_WORDS = 16;
    localparam int DEF_ADDR_W    = 32;

    // width of an index over n items, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lbl_transpose.sv
module lbl_transpose
    import lbl_pkg::*;
#(
    parameter int LANES     = DEF_LANES,
    parameter int ROW_WORDS = DEF_ROW_WORDS,
    parameter int WORD_W    = DEF_WORD_W
) (
    input  logic [LANES*ROW_WORDS*WORD_W-1:0] rows,
    output logic [ROW_WORDS*LANES*WORD_W-1:0] vecs
);
    localparam int ROW_W  = ROW_WORDS * WORD_W;
    localparam int VEC_W  = LANES * WORD_W;
    localparam int NBYTES = WORD_W / BYTE_W;

    // lane l, word k, byte b lands in vector k, slot l, byte NBYTES-1-b
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar k = 0; k < ROW_WORDS; k++) begin : g_word
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign vecs[k*VEC_W + l*WORD_W + (NBYTES-1-b)*BYTE_W +: BYTE_W] =
                    rows[l*ROW_W + k*WORD_W + b*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/lbl_lane_ptrs.sv
module lbl_lane_ptrs
    import lbl_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int STEP   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [LANES*ADDR_W-1:0] init,
    input  logic                    advance,
    output logic [LANES*ADDR_W-1:0] ptrs
);
    logic [LANES*ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = init;
        end else if (advance) begin
            for (int l = 0; l < LANES; l++) begin
                ptr_d[l*ADDR_W +: ADDR_W] = ptr_q[l*ADDR_W +: ADDR_W] + ADDR_W'(STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptrs = ptr_q;

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
            (advance && !load) |=> ptrs[l*ADDR_W +: ADDR_W] ==
                $past(ptrs[l*ADDR_W +: ADDR_W]) + ADDR_W'(STEP));
        p_ptr_load_r5: assert property (@(posedge clk) disable iff (rst)
            load |=> ptrs[l*ADDR_W +: ADDR_W] == $past(init[l*ADDR_W +: ADDR_W]));
        p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (!advance && !load) |=> $stable(ptrs[l*ADDR_W +: ADDR_W]));
    end
endmodule

// File: rtl/lbl_word_store.sv
module lbl_word_store
    import lbl_pkg::*;
#(
    parameter int ENTRIES   = DEF_BLK_WORDS,
    parameter int GRP_WORDS = DEF_ROW_WORDS,
    parameter int VEC_W     = DEF_LANES * DEF_WORD_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [idx_w(ENTRIES/GRP_WORDS)-1:0] wr_grp,
    input  logic [GRP_WORDS*VEC_W-1:0]        wr_vecs,
    input  logic [idx_w(ENTRIES)-1:0]         rd_idx,
    output logic [VEC_W-1:0]                  rd_data
);
    localparam int GRP_W = idx_w(ENTRIES / GRP_WORDS);

    logic [VEC_W-1:0] mem_d [ENTRIES];
    logic [VEC_W-1:0] mem_q [ENTRIES];

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) mem_d[e] = mem_q[e];
        if (wr_en) begin
            for (int k = 0; k < GRP_WORDS; k++) begin
                mem_d[int'(wr_grp) * GRP_WORDS + k] = wr_vecs[k*VEC_W +: VEC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (rst) mem_q[e] <= '0;
            else     mem_q[e] <= mem_d[e];
        end
    end

    assign rd_data = mem_q[rd_idx];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        p_store_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_grp == GRP_W'(e / GRP_WORDS)) |=> $stable(mem_q[e]));
        p_store_write_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_grp == GRP_W'(e / GRP_WORDS)) |=>
                mem_q[e] == $past(wr_vecs[(e % GRP_WORDS)*VEC_W +: VEC_W]));
    end
endmodule

// File: rtl/lane_block_loader.sv
module lane_block_loader
    import lbl_pkg::*;
#(
    parameter int LANES     = DEF_LANES,
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ROW_WORDS = DEF_ROW_WORDS,
    parameter int BLK_WORDS = DEF_BLK_WORDS,
    parameter int ADDR_W    = DEF_ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ptr_load,
    input  logic [LANES*ADDR_W-1:0]           ptr_init,
    output logic [LANES*ADDR_W-1:0]           lane_addr,
    input  logic                              row_valid,
    output logic                              row_ready,
    input  logic [LANES*ROW_WORDS*WORD_W-1:0] row_data,
    output logic                              done,
    output logic                              buf_full,
    input  logic                              consume,
    input  logic [idx_w(BLK_WORDS)-1:0]       rd_idx,
    output logic [LANES*WORD_W-1:0]           rd_word
);
    localparam int GROUPS   = BLK_WORDS / ROW_WORDS;
    localparam int GRP_W    = idx_w(GROUPS);
    localparam int VEC_W    = LANES * WORD_W;
    localparam int ROW_STEP = ROW_WORDS * WORD_W / BYTE_W;
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic             full;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;
    logic [ROW_WORDS*VEC_W-1:0] vecs;

    assign row_ready = !ctl_q.full && !ptr_load;
    assign accept    = row_valid && row_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) begin
            if (ctl_q.grp == LAST_GRP) begin
                ctl_d.grp  = '0;
                ctl_d.full = 1'b1;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.grp = ctl_q.grp + 1'b1;
            end
        end else if (consume && ctl_q.full) begin
            ctl_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign done     = ctl_q.done;
    assign buf_full = ctl_q.full;

    lbl_transpose #(
        .LANES(LANES), .ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W)
    ) u_xpose (
        .rows(row_data),
        .vecs(vecs)
    );

    lbl_word_store #(
        .ENTRIES(BLK_WORDS), .GRP_WORDS(ROW_WORDS), .VEC_W(VEC_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(accept), .wr_grp(ctl_q.grp), .wr_vecs(vecs),
        .rd_idx(rd_idx), .rd_data(rd_word)
    );

    lbl_lane_ptrs #(
        .LANES(LANES), .ADDR_W(ADDR_W), .STEP(ROW_STEP)
    ) u_ptrs (
        .clk(clk), .rst(rst),
        .load(ptr_load), .init(ptr_init), .advance(accept),
        .ptrs(lane_addr)
    );

    p_ready_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !row_ready);
    p_ready_load_r5: assert property (@(posedge clk) disable iff (rst)
        ptr_load |-> !row_ready);
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> buf_full);
    p_last_beat_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && ctl_q.grp == LAST_GRP) |=> (done && buf_full));
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_full && consume) |=> !buf_full);
    p_empty_consume_r8: assert property (@(posedge clk) disable iff (rst)
        (!buf_full && !accept) |=> !buf_full);
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!buf_full && !done && ctl_q.grp == '0));
endmodule

// File: tb/lane_block_loader_test.sv
module lane_block_loader_test;
    localparam int NL = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ptr_load = 1'b0;
    logic [127:0] ptr_init = '0;
    logic [127:0] lane_addr;
    logic         row_valid = 1'b0;
    logic         row_ready;
    logic [511:0] row_data = '0;
    logic         done;
    logic         buf_full;
    logic         consume = 1'b0;
    logic [3:0]   rd_idx = '0;
    logic [127:0] rd_word;

    int total = 0;
    int bad   = 0;
    logic [127:0] exp_vec [16];
    logic [31:0]  exp_ptr [NL];

    lane_block_loader uut (
        .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_init(ptr_init),
        .lane_addr(lane_addr), .row_valid(row_valid), .row_ready(row_ready),
        .row_data(row_data), .done(done), .buf_full(buf_full),
        .consume(consume), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ptr_vec();
        logic [127:0] v;
        for (int l = 0; l < NL; l++) v[l*32 +: 32] = exp_ptr[l];
        return v;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        finish_run();
    end

    // one accepted beat of group g; pattern selects directed word values
    task automatic beat(input int g, input bit pattern, input bit last);
        logic [511:0] rows;
        int gap;
        gap = $urandom_range(0, 2);
        for (int i = 0; i < gap; i++) @(negedge clk);
        @(negedge clk);
        for (int l = 0; l < NL; l++)
            for (int k = 0; k < 4; k++)
                rows[l*128 + k*32 +: 32] = pattern ?
                    {8'(l), 8'(g*4+k), 8'hA5, 8'h3C} : $urandom;
        row_data  = rows;
        row_valid = 1'b1;
        #1;
        check("R8 ready while empty", {127'd0, row_ready}, 128'd1);
        for (int k = 0; k < 4; k++)
            for (int l = 0; l < NL; l++)
                exp_vec[g*4+k][l*32 +: 32] = bswap(rows[l*128 + k*32 +: 32]);
        @(posedge clk);
        #1;
        for (int l = 0; l < NL; l++) exp_ptr[l] = exp_ptr[l] + 32'd16;
        check("R4 pointer step", lane_addr, ptr_vec());
        check("R6 done timing", {126'd0, done, buf_full}, last ? 128'd3 : 128'd0);
        @(negedge clk);
        row_valid = 1'b0;
    endtask

    task automatic blocked_and_read();
        @(posedge clk);
        #1;
        check("R6 done single cycle", {127'd0, done}, 128'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            row_valid = 1'b1;
            row_data  = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
            #1;
            check("R7 ready low while full", {127'd0, row_ready}, 128'd0);
            @(posedge clk);
            #1;
            check("R7 pointers held", lane_addr, ptr_vec());
        end
        @(negedge clk);
        row_valid = 1'b0;
        for (int e = 0; e < 16; e++) begin
            @(negedge clk);
            rd_idx = 4'(e);
            #1;
            check("R3 R1 R2 store entry", rd_word, exp_vec[e]);
        end
    endtask

    task automatic release_store();
        @(negedge clk);
        consume = 1'b1;
        @(posedge clk);
        #1;
        check("R8 full cleared", {127'd0, buf_full}, 128'd0);
        @(negedge clk);
        consume = 1'b0;
        #1;
        check("R8 ready again", {127'd0, row_ready}, 128'd1);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int l = 0; l < NL; l++) exp_ptr[l] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset outputs", {125'd0, row_ready, done, buf_full}, 128'd4);
        check("R9 reset pointers", lane_addr, 128'd0);

        // reload pointers, lane 3 close to wrap
        @(negedge clk);
        ptr_init  = {32'hFFFF_FFE0, 32'h0000_2000, 32'h0000_1000, 32'h8000_0000};
        ptr_load  = 1'b1;
        row_valid = 1'b1;
        #1;
        check("R5 ready low during load", {127'd0, row_ready}, 128'd0);
        @(posedge clk);
        #1;
        exp_ptr[0] = 32'h8000_0000; exp_ptr[1] = 32'h0000_1000;
        exp_ptr[2] = 32'h0000_2000; exp_ptr[3] = 32'hFFFF_FFE0;
        check("R5 pointers loaded", lane_addr, ptr_vec());
        @(negedge clk);
        ptr_load  = 1'b0;
        row_valid = 1'b0;

        // directed block with known words
        for (int g = 0; g < 4; g++) beat(g, 1'b1, g == 3);
        check("R4 lane3 wrapped", {96'd0, lane_addr[127:96]}, 128'h20);
        blocked_and_read();
        @(negedge clk);
        rd_idx = 4'd0;
        #1;
        check("R2 byte reversal", {96'd0, rd_word[31:0]}, 128'h3CA5_0000);
        rd_idx = 4'd5;
        #1;
        check("R1 lane slot order", {96'd0, rd_word[95:64]}, 128'h3CA5_0502);
        release_store();

        // consume while empty has no effect
        @(negedge clk);
        consume = 1'b1;
        @(posedge clk);
        #1;
        check("R8 empty consume", {126'd0, buf_full, row_ready}, 128'd1);
        @(negedge clk);
        consume = 1'b0;

        // pointer reload in the middle of a block keeps the beat count
        beat(0, 1'b0, 1'b0);
        beat(1, 1'b0, 1'b0);
        @(negedge clk);
        ptr_init = {32'h40, 32'h30, 32'h20, 32'h10};
        ptr_load = 1'b1;
        @(posedge clk);
        #1;
        for (int l = 0; l < NL; l++) exp_ptr[l] = 32'h10 * (l + 1);
        check("R5 mid-block reload", lane_addr, ptr_vec());
        @(negedge clk);
        ptr_load = 1'b0;
        beat(2, 1'b0, 1'b0);
        beat(3, 1'b0, 1'b1);
        blocked_and_read();
        release_store();

        // reset in the middle of a block
        beat(0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int l = 0; l < NL; l++) exp_ptr[l] = '0;
        check("R9 reset mid-block", {125'd0, row_ready, done, buf_full}, 128'd4);
        check("R9 reset pointers mid-block", lane_addr, 128'd0);
        for (int g = 0; g < 4; g++) beat(g, 1'b0, g == 3);
        blocked_and_read();
        release_store();

        // random blocks
        for (int b = 0; b < 6; b++) begin
            for (int g = 0; g < 4; g++) beat(g, 1'b0, g == 3);
            blocked_and_read();
            release_store();
        end

        finish_run();
    end
endmodule